// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This block is a real-time-clock peripheral on a plain 32-bit register bus. A slow clock-enable input is divided by a prescaler into a one-second tick. While counting is enabled, each tick advances a free-running 32-bit seconds count and raises a sticky one-second event. A 32-bit alarm word is compared against the value the count is about to take, and a match raises a sticky alarm event when the alarm is armed. Each event has its own interrupt enable, and the two masked events are merged into one registered interrupt line.

Event flags follow a keep-on-one, clear-on-zero rule, so a read-modify-write of the control word that writes ones into the flag positions never loses a pending event. Every accepted register write starts a busy window of a parameterised length, during which the write-ready bit reads 0. Writes issued inside that window are dropped and latch a sticky error output. Software reading the seconds count while it may tick reads it until two reads agree. The scratch word has no side effects and lets software detect lost state through a marker value it wrote earlier.

Top module: `sec_rtc`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0x00000080 (only write-ready set), the seconds, alarm, trim and scratch words read 0, and `irq` and `wr_err` are 0.
- R2: Byte addresses select the words: 0x00 control, 0x04 seconds, 0x08 alarm, 0x0C trim (storage only), 0x34 scratch. Seconds, alarm, trim and scratch are full 32-bit read/write words. Any other address reads 0 and ignores writes.
- R3: Control bit layout: bit 7 write-ready (read-only), bit 6 one-second flag, bit 5 one-second interrupt enable, bit 4 alarm flag, bit 3 alarm interrupt enable, bit 2 alarm arm, bit 0 count enable. All other bits read 0.
- R4: While count enable is 1, every PRESCALE-th `slow_en` pulse is a tick that adds 1 to the seconds count. The count wraps from 0xFFFFFFFF to 0.
- R5: Each tick sets the one-second flag (control bit 6).
- R6: A tick whose new count equals the alarm word sets the alarm flag (control bit 4), but only while alarm arm (bit 2) is 1.
- R7: Writing 0 to a flag bit clears that flag. Writing 1 leaves it unchanged. A tick in the same cycle still sets the flag.
- R8: `irq` is registered. It goes high one cycle after (bit 6 AND bit 5) OR (bit 4 AND bit 3) becomes true, and goes low one cycle after that term becomes false.
- R9: After an accepted write, write-ready reads 0 for exactly BUSY_CYC cycles.
- R10: A write issued while write-ready is 0 changes no register and sets `wr_err`. `wr_err` stays set until reset.
- R11: While count enable is 0, the seconds count holds and the prescaler is cleared.
- R12: An accepted write to the seconds word in the cycle of a tick takes priority. The tick is dropped, with no increment and no flags set, and the prescaler still restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_en | input | 1 | Slow clock enable, one-cycle pulses |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational on address) |
| irq | output | 1 | Registered interrupt |
| wr_err | output | 1 | Sticky write-while-busy error |

## Verification
The bench builds the block with PRESCALE = 3 and BUSY_CYC = 5. The short prescaler puts tick boundaries, counter wrap, alarm matches and a seconds write landing exactly on a tick within a few bus cycles. The busy length differs from its default, so the bench can count the not-ready cycles and see that they follow the parameter. It can also place a second write inside the window on purpose.

// File: rtl/sec_rtc_pkg.sv
// Package: shared address map and control bit positions for the seconds RTC.
// Assumes byte addressing on an 8-bit address bus with word-aligned accesses.
package sec_rtc_pkg;
    localparam logic [7:0] ADDR_CTRL    = 8'h00;
    localparam logic [7:0] ADDR_SECONDS = 8'h04;
    localparam logic [7:0] ADDR_ALARM   = 8'h08;
    localparam logic [7:0] ADDR_TRIM    = 8'h0C;
    localparam logic [7:0] ADDR_SCRATCH = 8'h34;

    localparam int CB_READY  = 7;
    localparam int CB_SFLAG  = 6;
    localparam int CB_SIE    = 5;
    localparam int CB_AFLAG  = 4;
    localparam int CB_AIE    = 3;
    localparam int CB_ARM    = 2;
    localparam int CB_RUN    = 0;

    typedef struct packed {
        logic sec_ie;
        logic alm_ie;
        logic alm_arm;
        logic run;
    } ctrl_cfg_t;
endpackage

// File: rtl/rtc_prescale.sv
// Module: divides slow_en pulses by PRESCALE into a one-cycle tick.
// Assumes PRESCALE >= 2; the divider is held cleared while run is 0.
module rtc_prescale #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow_en,
    output logic tick
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] div_q;

    assign tick = run && slow_en && (div_q == LAST);

    // Purpose: count slow enables, restart on each tick or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
        end else if (slow_en) begin
            div_q <= (div_q == LAST) ? '0 : div_q + PW'(1);
        end
    end

    a_r11_stopped_clear : assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (div_q == '0));
endmodule

// File: rtl/rtc_wr_gate.sv
// Module: write-busy handshake. Accepts a write only when idle, then holds
// ready low for BUSY_CYC cycles; a write while busy is dropped and flagged.
// Assumes BUSY_CYC >= 1.
module rtc_wr_gate #(
    parameter int BUSY_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    output logic wr_ok,
    output logic ready,
    output logic err
);
    localparam int CW = $clog2(BUSY_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC);

    logic [CW-1:0] busy_q;

    assign ready = (busy_q == '0);
    assign wr_ok = wr_req && ready;

    // Purpose: load the busy window on an accepted write and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_q <= '0;
        else if (wr_ok)      busy_q <= LOAD;
        else if (!ready)     busy_q <= busy_q - CW'(1);
    end

    // Purpose: remember any write attempted inside the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n)                 err <= 1'b0;
        else if (wr_req && !ready)  err <= 1'b1;
    end

    a_r9_busy_after_write : assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> !ready);
    a_r10_err_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/rtc_count.sv
// Module: 32-bit seconds counter with load and alarm compare.
// A load takes priority over a tick; alarm_hit marks a tick whose new value
// equals the alarm word while the alarm is armed.
module rtc_count #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    input  logic [SEC_W-1:0] alarm,
    input  logic             arm,
    output logic [SEC_W-1:0] sec,
    output logic             alarm_hit
);
    logic [SEC_W-1:0] next_sec;

    assign next_sec  = sec + SEC_W'(1);
    assign alarm_hit = tick && !load && arm && (next_sec == alarm);

    // Purpose: advance, load or hold the seconds count.
    always_ff @(posedge clk) begin
        if (!rst_n)      sec <= '0;
        else if (load)   sec <= load_val;
        else if (tick)   sec <= next_sec;
    end

    a_r4_step : assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> (sec == $past(sec) + SEC_W'(1)));
    a_r11_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(sec));
endmodule

// File: rtl/sec_rtc.sv
// Module: top of the seconds RTC. Holds the register file, event flags and
// the registered interrupt; uses the prescaler, write gate and counter.
// Assumes reads are side-effect free and the read port is combinational.
module sec_rtc #(
    parameter int PRESCALE = 32768,
    parameter int BUSY_CYC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_en,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        wr_err
);
    import sec_rtc_pkg::*;

    localparam int DW = 32;

    ctrl_cfg_t       cfg_q;
    logic            sflag_q, aflag_q;
    logic [DW-1:0]   alarm_q, trim_q, scratch_q, sec;
    logic            wr_ok, ready, tick, tick_eff, alarm_hit;
    logic            wr_ctrl, wr_sec;

    rtc_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(cfg_q.run), .slow_en(slow_en), .tick(tick)
    );

    rtc_wr_gate #(.BUSY_CYC(BUSY_CYC)) u_gate (
        .clk(clk), .rst_n(rst_n), .wr_req(bus_sel && bus_we),
        .wr_ok(wr_ok), .ready(ready), .err(wr_err)
    );

    assign wr_ctrl  = wr_ok && (bus_addr == ADDR_CTRL);
    assign wr_sec   = wr_ok && (bus_addr == ADDR_SECONDS);
    assign tick_eff = tick && !wr_sec;

    rtc_count #(.SEC_W(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(wr_sec),
        .load_val(bus_wdata), .alarm(alarm_q), .arm(cfg_q.alm_arm),
        .sec(sec), .alarm_hit(alarm_hit)
    );

    // Purpose: plain data words written through the accepted-write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q   <= '0;
            trim_q    <= '0;
            scratch_q <= '0;
        end else if (wr_ok) begin
            if (bus_addr == ADDR_ALARM)   alarm_q   <= bus_wdata;
            if (bus_addr == ADDR_TRIM)    trim_q    <= bus_wdata;
            if (bus_addr == ADDR_SCRATCH) scratch_q <= bus_wdata;
        end
    end

    // Purpose: control enables, written whole on an accepted control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_ctrl) begin
            cfg_q.sec_ie  <= bus_wdata[CB_SIE];
            cfg_q.alm_ie  <= bus_wdata[CB_AIE];
            cfg_q.alm_arm <= bus_wdata[CB_ARM];
            cfg_q.run     <= bus_wdata[CB_RUN];
        end
    end

    // Purpose: sticky flags; writing 0 clears, writing 1 keeps, events set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sflag_q <= 1'b0;
            aflag_q <= 1'b0;
        end else begin
            sflag_q <= (sflag_q && !(wr_ctrl && !bus_wdata[CB_SFLAG])) || tick_eff;
            aflag_q <= (aflag_q && !(wr_ctrl && !bus_wdata[CB_AFLAG])) || alarm_hit;
        end
    end

    // Purpose: registered merge of the masked events into one interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (sflag_q && cfg_q.sec_ie) || (aflag_q && cfg_q.alm_ie);
    end

    // Purpose: combinational read mux over the address map.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CB_READY] = ready;
                bus_rdata[CB_SFLAG] = sflag_q;
                bus_rdata[CB_SIE]   = cfg_q.sec_ie;
                bus_rdata[CB_AFLAG] = aflag_q;
                bus_rdata[CB_AIE]   = cfg_q.alm_ie;
                bus_rdata[CB_ARM]   = cfg_q.alm_arm;
                bus_rdata[CB_RUN]   = cfg_q.run;
            end
            ADDR_SECONDS: bus_rdata = sec;
            ADDR_ALARM:   bus_rdata = alarm_q;
            ADDR_TRIM:    bus_rdata = trim_q;
            ADDR_SCRATCH: bus_rdata = scratch_q;
            default:      bus_rdata = '0;
        endcase
    end

    a_r7_clear_sflag : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !bus_wdata[CB_SFLAG] && !tick_eff) |=> !sflag_q);
    a_r7_keep_aflag : assert property (@(posedge clk) disable iff (!rst_n)
        (aflag_q && !(wr_ctrl && !bus_wdata[CB_AFLAG])) |=> aflag_q);
    a_r8_irq_alarm : assert property (@(posedge clk) disable iff (!rst_n)
        (aflag_q && cfg_q.alm_ie) |=> irq);
    a_r12_load_wins : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sec && tick) |=> (sec == $past(bus_wdata)));
endmodule

// File: tb/sec_rtc_tb_top.sv
module sec_rtc_tb_top;
    localparam int PRE  = 3;
    localparam int BUSY = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wr_err;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    event        rd_ev;

    always #10 clk = ~clk;

    sec_rtc #(.PRESCALE(PRE), .BUSY_CYC(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .wr_err(wr_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected read value and compares against the bus.
    initial begin
        forever begin
            @(rd_ev);
            #1;
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wait_ready(output int busy_polls);
        busy_polls = 0;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 8'h00;
        #1;
        while (bus_rdata[7] !== 1'b1) begin
            busy_polls++;
            @(negedge clk);
            #1;
        end
        bus_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic raw_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        int p;
        wait_ready(p);
        raw_write(a, d);
    endtask

    // Driver: pushes the expected value and triggers the monitor.
    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        int p;
        wait_ready(p);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        -> rd_ev;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse();
        slow_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        slow_en = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) pulse();
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int polls;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 wr_err", {31'b0, wr_err}, 32'h0);
        rd(8'h00, 32'h80, "R1 ctrl");
        rd(8'h04, 32'h0, "R1 seconds");
        rd(8'h08, 32'h0, "R1 alarm");
        rd(8'h34, 32'h0, "R1 scratch");

        // R2 address map
        wr(8'h34, 32'h12345678);
        rd(8'h34, 32'h12345678, "R2 scratch");
        wr(8'h0C, 32'hA5A50F0F);
        rd(8'h0C, 32'hA5A50F0F, "R2 trim");
        wr(8'h10, 32'hFFFFFFFF);
        rd(8'h10, 32'h0, "R2 unmapped");
        rd(8'h08, 32'h0, "R2 alarm untouched");

        // R9 busy window length
        wr(8'h34, 32'hCAFEF00D);
        wait_ready(polls);
        check("R9 busy cycles", polls, BUSY);

        // R10 write while busy dropped
        raw_write(8'h34, 32'h11111111);
        raw_write(8'h34, 32'h22222222);
        rd(8'h34, 32'h11111111, "R10 scratch kept");
        check("R10 wr_err", {31'b0, wr_err}, 32'h1);

        // R3 control layout
        wr(8'h00, 32'hFFFFFFFF);
        rd(8'h00, 32'hAD, "R3 ctrl mask");
        wr(8'h00, 32'h0);
        rd(8'h00, 32'h80, "R3 ctrl cleared");

        // R4 / R5 ticking
        wr(8'h04, 32'd10);
        wr(8'h00, 32'h01);
        pulses(2);
        rd(8'h04, 32'd10, "R4 no tick yet");
        pulse();
        rd(8'h04, 32'd11, "R4 tick");
        rd(8'h00, 32'hC1, "R5 sec flag");

        // R11 stopped counter, R7 clear by 0
        wr(8'h00, 32'h40);
        pulses(3);
        rd(8'h04, 32'd11, "R11 hold");
        rd(8'h00, 32'hC0, "R7 flag kept by 1");
        wr(8'h00, 32'h01);
        rd(8'h00, 32'h81, "R7 flag cleared by 0");

        // R4 wrap
        wr(8'h04, 32'hFFFFFFFF);
        pulses(3);
        rd(8'h04, 32'h0, "R4 wrap");

        // R6 / R8 alarm
        wr(8'h08, 32'd5);
        wr(8'h04, 32'd4);
        wr(8'h00, 32'h0D);
        pulses(3);
        check("R8 irq not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R8 irq raised", {31'b0, irq}, 32'h1);
        rd(8'h00, 32'hDD, "R6 alarm flag");

        // R7 / R8 flag handling through read-modify-write
        wr(8'h00, 32'h4D);
        rd(8'h00, 32'hCD, "R7 alarm flag cleared");
        check("R8 irq dropped", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'h6D);
        rd(8'h00, 32'hED, "R7 sec flag kept");
        check("R8 irq sec", {31'b0, irq}, 32'h1);
        wr(8'h00, 32'h0D);
        rd(8'h00, 32'h8D, "R7 sec flag cleared");
        check("R8 irq low", {31'b0, irq}, 32'h0);

        // R6 disarmed alarm
        wr(8'h08, 32'd6);
        wr(8'h00, 32'h09);
        pulses(3);
        rd(8'h04, 32'd6, "R6 count at alarm");
        rd(8'h00, 32'hC9, "R6 disarmed no flag");
        check("R6 irq off", {31'b0, irq}, 32'h0);

        // R12 load on tick cycle
        wr(8'h00, 32'h01);
        wr(8'h04, 32'd100);
        pulses(2);
        wait_ready(polls);
        slow_en = 1'b1;
        raw_write(8'h04, 32'd200);
        slow_en = 1'b0;
        rd(8'h04, 32'd200, "R12 load wins");
        rd(8'h00, 32'h81, "R12 no flag");
        pulses(3);
        rd(8'h04, 32'd201, "R12 prescaler restarted");

        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule